// File: doc/BRIEF.md
# Load/Store Integer-Float Quantizer

The quantizer sits beside the ordinary load/store datapath, between a data-cache port and a paired floating-point register. It has two independent pipelines.

The load pipeline takes one or two packed small integers from memory and expands them into single-precision values for the two 32-bit lanes of a register. The store pipeline narrows one or two single-precision lanes into packed 8-bit or 16-bit integers for memory. Each path applies a power-of-two scale during conversion. Compressed graphics data can therefore move at 4:1 (bytes) or 2:1 (halfwords) without separate conversion instructions.

Each path has its own plain configuration pins: an element type and a signed 6-bit scale exponent. They are sampled in the cycle a beat is accepted.

Both data interfaces use valid/ready:
- A beat transfers on a clock edge where valid and ready are both high.
- A producer holding valid must keep its beat unchanged until it is taken.
- An output that is stalled by a low ready keeps its data unchanged.
- Each path has two register stages. An unstalled path accepts a new beat every cycle.

Top module: `qz_quantizer`

## Requirements
- R1: The element type code works as follows:
  - Bit 2 set means integer; bit 2 clear (codes 0 to 3) means float passthrough.
  - Bit 1 set means signed.
  - Bit 0 set means 16-bit; clear means 8-bit.
  
  On load, each integer element becomes the exact single-precision value of the integer times 2^-scale, where the scale is a signed 6-bit value. A zero element gives +0.0.
- R2: On load, lane 0 takes the lowest element of the input word and lane 1 the next one:
  - 8-bit elements: lane 0 is bits 7:0 and lane 1 is bits 15:8.
  - 16-bit elements: lane 0 is bits 15:0 and lane 1 is bits 31:16.
  - Floats: lane 0 is bits 31:0 and lane 1 is bits 63:32.
  
  Output lane 0 is bits 31:0 and output lane 1 is bits 63:32.
- R3: A load beat with the pair flag low converts only lane 0, and output lane 1 is 1.0 (0x3F800000).
- R4: In float passthrough mode, the lanes are copied unchanged on both paths and the scale has no effect.
- R5: On store, each single-precision lane is multiplied by 2^+scale and truncated toward zero. Zero and denormal inputs store 0.
- R6: A store result beyond the range of the selected type saturates to that type's minimum or maximum. Infinities saturate by sign. Unsigned types store 0 for negative inputs.
- R7: A NaN store input gives integer 0.
- R8: Store output packing:
  - 8-bit results go in bits 7:0 (lane 0) and 15:8 (lane 1).
  - 16-bit results go in bits 15:0 and 31:16.
  - Passthrough floats go in bits 31:0 and 63:32.
  - Every bit above the packed elements is 0.
  - With the pair flag low, lane 1's field is 0 whatever its input was.
- R9: When not stalled, a result appears on the output exactly 2 clock edges after its beat is accepted, and input ready stays high so that one beat per cycle flows.
- R10: Beats leave each path in acceptance order, none lost or repeated. A stalled output holds its valid and data.
- R11: The type and scale used for a beat are those present in the cycle it was accepted. Later changes do not affect beats already in flight.
- R12: During and right after reset, both output valids are low and both input readies are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_type | input | 3 | Load element type code |
| ld_scale | input | 6 | Load scale exponent, signed |
| st_type | input | 3 | Store element type code |
| st_scale | input | 6 | Store scale exponent, signed |
| ld_in_valid | input | 1 | Load input beat valid |
| ld_in_ready | output | 1 | Load path can accept a beat |
| ld_in_pair | input | 1 | Load beat carries two elements |
| ld_in_data | input | 64 | Packed elements from memory |
| ld_out_valid | output | 1 | Load result valid |
| ld_out_ready | input | 1 | Register side takes the load result |
| ld_out_data | output | 64 | Two single-precision lanes |
| st_in_valid | input | 1 | Store input beat valid |
| st_in_ready | output | 1 | Store path can accept a beat |
| st_in_pair | input | 1 | Store beat carries two elements |
| st_in_data | input | 64 | Two single-precision lanes |
| st_out_valid | output | 1 | Store result valid |
| st_out_ready | input | 1 | Memory side takes the store result |
| st_out_data | output | 64 | Packed integers or passthrough floats |

## Verification
Every converted beat is due at the output 2 edges after its accepting edge, and later only while ready holds it back. The bench drives inputs on the falling edge and samples 1 ns later. At that point the handshakes of the coming rising edge are already decided, so each accepted beat is paired with its expected result in a per-path queue and compared when the output handshake happens. In the directed phase and the full-rate phase, output ready stays high, and each result's arrival cycle minus its acceptance cycle must be exactly 2. In the random phase ready and the configuration change freely, and order, holding and values are checked.

// File: rtl/qz_pkg.sv
`timescale 1ns/1ps
package qz_pkg;
  localparam int LANES   = 2;
  localparam int F_W     = 32;
  localparam int DATA_W  = LANES * F_W;
  localparam int SCALE_W = 6;
  localparam int TYPE_W  = 3;
  localparam logic [F_W-1:0] F_ONE = 32'h3F80_0000;

  // type code: [2]=integer, [1]=signed, [0]=16-bit element
  typedef struct packed {
    logic [TYPE_W-1:0]  typ;
    logic [SCALE_W-1:0] scale;
    logic               pair;
    logic [DATA_W-1:0]  data;
  } qz_beat_t;
endpackage

// File: rtl/qz_slice.sv
`timescale 1ns/1ps
module qz_slice #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R9
  take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid && out_data == $past(in_data));
endmodule

// File: rtl/qz_load_lane.sv
`timescale 1ns/1ps
module qz_load_lane
  import qz_pkg::*;
(
  input  logic [TYPE_W-1:0]  typ,
  input  logic [SCALE_W-1:0] scale,
  input  logic [7:0]         e8,
  input  logic [15:0]        e16,
  input  logic [F_W-1:0]     f32,
  output logic [F_W-1:0]     fp
);
  logic signed [16:0] v;
  logic        neg;
  logic [15:0] mag;
  logic [3:0]  p;
  logic [22:0] frac;
  logic [7:0]  expo;

  always_comb begin
    unique case (typ[1:0])
      2'b00:   v = {9'd0, e8};
      2'b01:   v = {1'b0, e16};
      2'b10:   v = {{9{e8[7]}}, e8};
      default: v = {e16[15], e16};
    endcase
    neg = v[16];
    mag = 16'(neg ? (17'd0 - v) : v);
    p = '0;
    for (int i = 0; i < 16; i++) if (mag[i]) p = 4'(i);
    frac = 23'({8'd0, mag} << (5'd23 - {1'b0, p}));
    expo = 8'(10'd127 + {6'd0, p} - {{(10-SCALE_W){scale[SCALE_W-1]}}, scale});
    if (!typ[2])        fp = f32;
    else if (mag == '0) fp = '0;
    else                fp = {neg, expo, frac};
  end
endmodule

// File: rtl/qz_store_lane.sv
`timescale 1ns/1ps
module qz_store_lane
  import qz_pkg::*;
(
  input  logic [TYPE_W-1:0]  typ,
  input  logic [SCALE_W-1:0] scale,
  input  logic [F_W-1:0]     f,
  output logic [15:0]        q
);
  logic        sgn, nan, zero, big;
  logic [7:0]  ex;
  logic signed [10:0] e;
  logic [16:0] mag, pmax, nmax, m;

  always_comb begin
    sgn  = f[31];
    ex   = f[30:23];
    nan  = (ex == 8'hFF) && (f[22:0] != '0);
    e    = $signed({3'b0, ex}) - 11'sd127
         + $signed({{(11-SCALE_W){scale[SCALE_W-1]}}, scale});
    zero = (ex == 8'h00) || nan || e[10];
    big  = !zero && (e[9:4] != '0);
    mag  = '0;
    if (!zero && !big)
      mag = 17'({1'b1, f[22:0]} >> (5'd23 - {1'b0, e[3:0]}));
    unique case (typ[1:0])
      2'b00:   begin pmax = 17'd255;   nmax = 17'd0;     end
      2'b01:   begin pmax = 17'd65535; nmax = 17'd0;     end
      2'b10:   begin pmax = 17'd127;   nmax = 17'd128;   end
      default: begin pmax = 17'd32767; nmax = 17'd32768; end
    endcase
    if (zero)      q = '0;
    else if (!sgn) q = 16'((big || mag > pmax) ? pmax : mag);
    else begin
      m = (big || mag > nmax) ? nmax : mag;
      q = 16'(17'd0 - m);
    end
  end
endmodule

// File: rtl/qz_quantizer.sv
`timescale 1ns/1ps
module qz_quantizer
  import qz_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [TYPE_W-1:0]  ld_type,
  input  logic [SCALE_W-1:0] ld_scale,
  input  logic [TYPE_W-1:0]  st_type,
  input  logic [SCALE_W-1:0] st_scale,
  input  logic               ld_in_valid,
  output logic               ld_in_ready,
  input  logic               ld_in_pair,
  input  logic [DATA_W-1:0]  ld_in_data,
  output logic               ld_out_valid,
  input  logic               ld_out_ready,
  output logic [DATA_W-1:0]  ld_out_data,
  input  logic               st_in_valid,
  output logic               st_in_ready,
  input  logic               st_in_pair,
  input  logic [DATA_W-1:0]  st_in_data,
  output logic               st_out_valid,
  input  logic               st_out_ready,
  output logic [DATA_W-1:0]  st_out_data
);
  localparam int BW = $bits(qz_beat_t);

  qz_beat_t ld_a, st_a;
  logic ld_a_v, st_a_v, ld_b_rdy, st_b_rdy;
  logic [F_W-1:0] ld_fp [LANES];
  logic [15:0]    st_q  [LANES];
  logic [DATA_W-1:0] ld_pack, st_pack;

  qz_slice #(.W(BW)) u_ld_a (
    .clk, .rst_n,
    .in_valid(ld_in_valid), .in_ready(ld_in_ready),
    .in_data({ld_type, ld_scale, ld_in_pair, ld_in_data}),
    .out_valid(ld_a_v), .out_ready(ld_b_rdy), .out_data(ld_a));

  qz_slice #(.W(BW)) u_st_a (
    .clk, .rst_n,
    .in_valid(st_in_valid), .in_ready(st_in_ready),
    .in_data({st_type, st_scale, st_in_pair, st_in_data}),
    .out_valid(st_a_v), .out_ready(st_b_rdy), .out_data(st_a));

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    qz_load_lane u_ll (
      .typ(ld_a.typ), .scale(ld_a.scale),
      .e8(ld_a.data[8*l +: 8]), .e16(ld_a.data[16*l +: 16]),
      .f32(ld_a.data[F_W*l +: F_W]), .fp(ld_fp[l]));
    qz_store_lane u_sl (
      .typ(st_a.typ), .scale(st_a.scale),
      .f(st_a.data[F_W*l +: F_W]), .q(st_q[l]));
  end

  always_comb begin
    ld_pack = '0;
    st_pack = '0;
    for (int l = 0; l < LANES; l++) begin
      ld_pack[F_W*l +: F_W] = (l == 0 || ld_a.pair) ? ld_fp[l] : F_ONE;
      if (l == 0 || st_a.pair) begin
        if (!st_a.typ[2])     st_pack[F_W*l +: F_W] = st_a.data[F_W*l +: F_W];
        else if (st_a.typ[0]) st_pack[16*l +: 16]   = st_q[l];
        else                  st_pack[8*l +: 8]     = st_q[l][7:0];
      end
    end
  end

  qz_slice #(.W(DATA_W)) u_ld_b (
    .clk, .rst_n,
    .in_valid(ld_a_v), .in_ready(ld_b_rdy), .in_data(ld_pack),
    .out_valid(ld_out_valid), .out_ready(ld_out_ready), .out_data(ld_out_data));

  qz_slice #(.W(DATA_W)) u_st_b (
    .clk, .rst_n,
    .in_valid(st_a_v), .in_ready(st_b_rdy), .in_data(st_pack),
    .out_valid(st_out_valid), .out_ready(st_out_ready), .out_data(st_out_data));

  // R1
  zero_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_a_v && ld_a.typ[2] && ld_a.data[15:0] == '0 |-> ld_fp[0] == '0);

  // R7
  nan_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_a_v && st_a.typ[2] && st_a.data[30:23] == 8'hFF && st_a.data[22:0] != '0
    |-> st_q[0] == '0);

  // R6
  u8_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_a_v && st_a.typ == 3'b100 |-> st_q[0][15:8] == '0);

  // R6
  s8_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_a_v && st_a.typ == 3'b110 |-> $countones(st_q[0][15:7]) == 0 ||
                                    $countones(st_q[0][15:7]) == 9);
endmodule

// File: tb/qz_quantizer_test.sv
`timescale 1ns/1ps
module qz_quantizer_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;
  logic rst_n;
  logic [2:0] ld_type, st_type;
  logic [5:0] ld_scale, st_scale;
  logic ld_in_valid, ld_in_ready, ld_in_pair, ld_out_valid, ld_out_ready;
  logic st_in_valid, st_in_ready, st_in_pair, st_out_valid, st_out_ready;
  logic [63:0] ld_in_data, ld_out_data, st_in_data, st_out_data;

  qz_quantizer uut (.*);

  int total = 0, bad = 0, cyc = 0;
  bit lat_mode = 0, done = 0, ld_fired, st_fired, ld_hold = 0, st_hold = 0;
  logic [63:0] ld_prev, st_prev;
  logic [63:0] ld_q[$], st_q[$];
  int ld_t[$], st_t[$];
  string ld_g[$], st_g[$];
  string ld_tag = "R1", st_tag = "R5";

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [31:0] m_i2f(int v, int sc);
    real r;
    logic [63:0] d;
    int ex;
    if (v == 0) return 32'h0;
    r = real'(v) * (2.0 ** real'(-sc));
    d = $realtobits(r);
    ex = int'(d[62:52]) - 1023 + 127;
    return {d[63], 8'(ex), d[51:29]};
  endfunction

  function automatic logic [63:0] m_load(logic [2:0] t, int sc, logic pr, logic [63:0] d);
    logic [63:0] o = '0;
    for (int i = 0; i < 2; i++) begin
      logic [31:0] f;
      logic [15:0] raw;
      int v;
      if (!t[2]) f = d[32*i +: 32];
      else begin
        raw = t[0] ? d[16*i +: 16] : {8'd0, d[8*i +: 8]};
        if (t[1]) v = t[0] ? int'($signed(raw)) : int'($signed(raw[7:0]));
        else      v = int'(raw);
        f = m_i2f(v, sc);
      end
      if (i == 1 && !pr) f = 32'h3F80_0000;
      o[32*i +: 32] = f;
    end
    return o;
  endfunction

  function automatic int m_f2i(logic [31:0] f, logic [2:0] t, int sc);
    int lo, hi;
    int ex = int'(f[30:23]);
    real r;
    case (t[1:0])
      2'b00: begin lo = 0; hi = 255; end
      2'b01: begin lo = 0; hi = 65535; end
      2'b10: begin lo = -128; hi = 127; end
      default: begin lo = -32768; hi = 32767; end
    endcase
    if (ex == 255) return (f[22:0] != 0) ? 0 : (f[31] ? lo : hi);
    if (ex == 0) return 0;
    r = $bitstoreal({f[31], 11'(ex - 127 + 1023), f[22:0], 29'd0}) * (2.0 ** real'(sc));
    if (r >= real'(hi)) return hi;
    if (r <= real'(lo)) return lo;
    return $rtoi(r);
  endfunction

  function automatic logic [63:0] m_store(logic [2:0] t, int sc, logic pr, logic [63:0] d);
    logic [15:0] a, b;
    if (!t[2]) return {pr ? d[63:32] : 32'd0, d[31:0]};
    a = 16'(m_f2i(d[31:0], t, sc));
    b = pr ? 16'(m_f2i(d[63:32], t, sc)) : 16'd0;
    return t[0] ? {32'd0, b, a} : {48'd0, b[7:0], a[7:0]};
  endfunction

  // settle 1 ns after the falling edge, account the handshakes of the next rising edge
  task automatic tick();
    logic [63:0] e;
    int t0;
    string g;
    #1;
    ld_fired = 0; st_fired = 0;
    if (ld_hold) chk(ld_out_valid && ld_out_data == ld_prev, "R10", ld_out_data, ld_prev);
    if (st_hold) chk(st_out_valid && st_out_data == st_prev, "R10", st_out_data, st_prev);
    if (lat_mode) begin
      chk(ld_in_ready, "R9", 64'(ld_in_ready), 64'd1);
      chk(st_in_ready, "R9", 64'(st_in_ready), 64'd1);
    end
    if (ld_in_valid && ld_in_ready) begin
      ld_fired = 1;
      ld_q.push_back(m_load(ld_type, int'($signed(ld_scale)), ld_in_pair, ld_in_data));
      ld_t.push_back(cyc); ld_g.push_back(ld_tag);
    end
    if (st_in_valid && st_in_ready) begin
      st_fired = 1;
      st_q.push_back(m_store(st_type, int'($signed(st_scale)), st_in_pair, st_in_data));
      st_t.push_back(cyc); st_g.push_back(st_tag);
    end
    if (ld_out_valid && ld_out_ready) begin
      if (ld_q.size() == 0) chk(0, "R10", ld_out_data, 64'd0);
      else begin
        e = ld_q.pop_front(); t0 = ld_t.pop_front(); g = ld_g.pop_front();
        chk(ld_out_data == e, g, ld_out_data, e);
        if (lat_mode) chk(cyc - t0 == 2, "R9", 64'(cyc - t0), 64'd2);
      end
    end
    if (st_out_valid && st_out_ready) begin
      if (st_q.size() == 0) chk(0, "R10", st_out_data, 64'd0);
      else begin
        e = st_q.pop_front(); t0 = st_t.pop_front(); g = st_g.pop_front();
        chk(st_out_data == e, g, st_out_data, e);
        if (lat_mode) chk(cyc - t0 == 2, "R9", 64'(cyc - t0), 64'd2);
      end
    end
    ld_hold = ld_out_valid && !ld_out_ready; ld_prev = ld_out_data;
    st_hold = st_out_valid && !st_out_ready; st_prev = st_out_data;
    cyc++;
    @(negedge clk);
  endtask

  task automatic send_ld(logic [2:0] t, logic [5:0] sc, logic pr, logic [63:0] d, string g);
    ld_type = t; ld_scale = sc; ld_in_pair = pr; ld_in_data = d; ld_tag = g;
    ld_in_valid = 1;
    do tick(); while (!ld_fired);
    ld_in_valid = 0;
  endtask

  task automatic send_st(logic [2:0] t, logic [5:0] sc, logic pr, logic [63:0] d, string g);
    st_type = t; st_scale = sc; st_in_pair = pr; st_in_data = d; st_tag = g;
    st_in_valid = 1;
    do tick(); while (!st_fired);
    st_in_valid = 0;
  endtask

  function automatic logic [31:0] rnd_f();
    if ($urandom % 4 == 0) return $urandom;
    return {1'($urandom), 8'(118 + $urandom % 30), 23'($urandom)};
  endfunction

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0;
    ld_type = 0; ld_scale = 0; st_type = 0; st_scale = 0;
    ld_in_valid = 0; ld_in_pair = 0; ld_in_data = 0; ld_out_ready = 0;
    st_in_valid = 0; st_in_pair = 0; st_in_data = 0; st_out_ready = 0;
    repeat (3) @(negedge clk);
    #1;
    // R12: in reset
    chk(!ld_out_valid && !st_out_valid && ld_in_ready && st_in_ready, "R12",
        {ld_out_valid, st_out_valid, ld_in_ready, st_in_ready}, 64'b0011);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #1;
    // R12: right after reset
    chk(!ld_out_valid && !st_out_valid && ld_in_ready && st_in_ready, "R12",
        {ld_out_valid, st_out_valid, ld_in_ready, st_in_ready}, 64'b0011);
    @(negedge clk);

    // directed corners, output always ready, exact latency
    ld_out_ready = 1; st_out_ready = 1; lat_mode = 1;
    send_ld(3'b100, 6'd0, 1, 64'h0000_0000_0000_FF00, "R2");   // u8 pair: 0, 255.0
    send_ld(3'b101, 6'd2, 1, 64'h0000_0000_0003_0010, "R2");   // u16 pair
    send_ld(3'b110, 6'd3, 0, 64'h0000_0000_0000_7F80, "R3");   // s8 single -128
    send_ld(3'b111, 6'b100000, 1, 64'h0000_0000_7FFF_8000, "R1"); // s16 extremes, scale -32
    send_ld(3'b101, 6'd31, 0, 64'h0000_0000_0000_FFFF, "R1");  // u16 max, scale 31
    send_ld(3'b110, 6'd5, 1, 64'h0000_0000_0000_0100, "R1");   // zero and 1
    send_ld(3'b010, 6'd7, 1, 64'hC123_4567_7FC0_0001, "R4");   // passthrough pair
    send_ld(3'b000, 6'd9, 0, 64'hDEAD_BEEF_4049_0FDB, "R4");   // passthrough single
    send_st(3'b100, 6'd0, 1, 64'hC040_0000_4396_0000, "R6");   // u8: 300 -> 255, -3 -> 0
    send_st(3'b110, 6'd0, 1, 64'h7F80_0000_C348_0000, "R6");   // s8: -200 -> -128, +inf -> 127
    send_st(3'b111, 6'd0, 1, 64'hFF80_0000_7FC0_0000, "R7");   // s16: NaN -> 0, -inf -> -32768
    send_st(3'b101, 6'd4, 0, 64'hBF40_0000_3FC0_0000, "R5");   // u16: 1.5*16 = 24, single
    send_st(3'b111, 6'd1, 1, 64'h4060_0000_C030_0000, "R5");   // -2.75 -> -5, 3.5*2 -> 7
    send_st(3'b111, 6'b111110, 1, 64'hBF7F_FFFF_3F7F_FFFF, "R5"); // tiny -> 0
    send_st(3'b001, 6'd3, 0, 64'h1234_5678_C2F6_E979, "R8");   // passthrough single
    send_st(3'b011, 6'd3, 1, 64'h7FC0_0000_0000_0001, "R4");   // passthrough pair
    send_st(3'b100, 6'd2, 0, 64'h4300_0000_3F80_0000, "R8");   // u8 single: 4, lane 1 dropped
    send_st(3'b110, 6'd1, 1, 64'hC2FE_0000_42FE_0000, "R8");   // s8 pair 127*2 sat
    repeat (4) tick();

    // random traffic, random back-pressure, config changes every cycle
    lat_mode = 0; ld_tag = "R11"; st_tag = "R11";
    for (int n = 0; n < 3000; n++) begin
      if (!ld_in_valid || ld_fired) begin
        ld_in_valid = ($urandom % 10) < 7;
        ld_in_pair = 1'($urandom); ld_in_data = {$urandom, $urandom};
      end
      if (!st_in_valid || st_fired) begin
        st_in_valid = ($urandom % 10) < 7;
        st_in_pair = 1'($urandom); st_in_data = {rnd_f(), rnd_f()};
      end
      ld_type = 3'($urandom); ld_scale = 6'($urandom);
      st_type = 3'($urandom); st_scale = 6'($urandom);
      ld_out_ready = ($urandom % 10) < 6;
      st_out_ready = ($urandom % 10) < 6;
      tick();
    end
    ld_in_valid = 0; st_in_valid = 0; ld_out_ready = 1; st_out_ready = 1;
    repeat (6) tick();

    // full rate: valid and ready always high
    lat_mode = 1; ld_tag = "R9"; st_tag = "R9";
    for (int n = 0; n < 500; n++) begin
      ld_in_valid = 1; st_in_valid = 1;
      ld_in_pair = 1'($urandom); ld_in_data = {$urandom, $urandom};
      st_in_pair = 1'($urandom); st_in_data = {rnd_f(), rnd_f()};
      ld_type = 3'($urandom); ld_scale = 6'($urandom);
      st_type = 3'($urandom); st_scale = 6'($urandom);
      tick();
    end
    ld_in_valid = 0; st_in_valid = 0;
    repeat (6) tick();
    lat_mode = 0;
    // R10: nothing left unaccounted
    chk(ld_q.size() == 0 && st_q.size() == 0 && !ld_out_valid && !st_out_valid, "R10",
        64'(ld_q.size() + st_q.size()), 64'd0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired (R9) act=%0d exp=finished", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule